// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This block corrects the result of a binary addition of two packed-BCD bytes so that it becomes valid packed BCD again. Each nibble of the byte holds one decimal digit. The inputs are the raw sum, the carry flag from the addition, and the nibble carry flag from the addition. The block returns the corrected byte and an updated carry flag. It does not touch the nibble carry flag or any overflow indication; these pass through outside the block.

The low digit is corrected by a 3-bit adder that works on bits 3..1. Adding six equals adding three to those bits, so bit 0 needs no logic. The high digit has two 4-bit adders that compute the uncorrected and the corrected candidates at the same time. Both candidates take the low-digit carry as carry-in. A select built from the incoming carry flag and the candidate's own carry and range then picks the final high digit. The datapath is combinational. A parameter can place a register stage on the outputs.

Top module: `bcd_adj_unit`

## Requirements
- R1: Bit 0 of the adjusted byte always equals bit 0 of the input byte.
- R2: When the low digit (bits 3..0) is above 9, or the nibble carry input is 1, six is added to the low digit.
- R3: When the low digit is 9 or below and the nibble carry input is 0, the low digit passes through unchanged.
- R4: A carry out of the low-digit correction adds one to the high digit before the high digit is checked for range.
- R5: Six is added to the high digit (bits 7..4) when, after any low carry, it is above 9 or it overflowed, or when the carry input is 1.
- R6: The carry output is 1 when the high-digit correction carries past bit 7.
- R7: The carry output is 1 whenever the carry input is 1. The adjust never clears carry.
- R8: If both digits are 0..9 and both flag inputs are 0, the byte passes through unchanged and the carry output is 0.
- R9: With REG_OUT=1, the outputs appear one clock after the inputs. While rst_ni is low, the outputs are 0.
- R10: With REG_OUT=0, the outputs follow the inputs in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_i | input | 8 | Raw binary sum of two packed-BCD bytes |
| cy_i | input | 1 | Carry flag produced by the addition |
| ac_i | input | 1 | Nibble carry flag produced by the addition |
| acc_o | output | 8 | Adjusted packed-BCD byte |
| cy_o | output | 1 | Updated carry flag |

## Verification
The hardest case to reach is a chain of carries. The low correction carries, that carry pushes a high digit of 9 or 15 out of range or past its top, and the high correction then carries out of the byte. Directed vectors such as 0x9A and 0xFF with the flags clear set up this chain. The bench also sweeps every byte value against all four flag combinations. It compares both the registered variant and the combinational variant with a reference built from plain integer arithmetic.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int unsigned DIG_W   = 4;
  localparam int unsigned BYTE_W  = 2 * DIG_W;
  localparam int unsigned DIG_MAX = 9;
  localparam int unsigned DIG_FIX = 6;
  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bcd_lo_fix.sv
module bcd_lo_fix
  import bcd_adj_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  digit_t nib_i,
  input  logic   ac_i,
  output digit_t nib_o,
  output logic   carry_o
);
  localparam int unsigned UP_W = DIG_W - 1;
  localparam logic [UP_W:0] HALF_FIX = (UP_W+1)'(DIG_FIX / 2);

  logic [UP_W:0] upper_sum;
  logic          fix;

  // adding six == adding three to bits 3..1; bit 0 untouched
  assign upper_sum = {1'b0, nib_i[DIG_W-1:1]} + HALF_FIX;
  assign fix       = ac_i | (nib_i > digit_t'(DIG_MAX));
  assign nib_o     = fix ? {upper_sum[UP_W-1:0], nib_i[0]} : nib_i;
  assign carry_o   = fix & upper_sum[UP_W];

  AST_LO_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_o[0] == nib_i[0]); // R1
  AST_LO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ac_i && nib_i <= digit_t'(DIG_MAX)) |-> (nib_o == nib_i && !carry_o)); // R3
  AST_LO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (nib_o < digit_t'(DIG_FIX))); // R2
endmodule

// File: rtl/bcd_hi_fix.sv
module bcd_hi_fix
  import bcd_adj_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  digit_t nib_i,
  input  logic   cin_i,
  input  logic   cy_i,
  output digit_t nib_o,
  output logic   cy_o
);
  localparam int unsigned SUM_W = DIG_W + 1;

  logic [SUM_W-1:0] plain_sum;
  logic [SUM_W-1:0] fixed_sum;
  logic             fix;

  // both candidates in parallel, selected late
  assign plain_sum = {1'b0, nib_i} + {{DIG_W{1'b0}}, cin_i};
  assign fixed_sum = {1'b0, nib_i} + SUM_W'(DIG_FIX) + {{DIG_W{1'b0}}, cin_i};
  assign fix       = cy_i | plain_sum[DIG_W] | (plain_sum[DIG_W-1:0] > digit_t'(DIG_MAX));
  assign nib_o     = fix ? fixed_sum[DIG_W-1:0] : plain_sum[DIG_W-1:0];
  assign cy_o      = cy_i | (fix & fixed_sum[DIG_W]);

  AST_HI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cy_i |-> cy_o); // R7
  AST_HI_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cy_i && !cin_i && nib_i <= digit_t'(DIG_MAX)) |-> (nib_o == nib_i && !cy_o)); // R8
endmodule

// File: rtl/bcd_adj_unit.sv
module bcd_adj_unit
  import bcd_adj_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] acc_i,
  input  logic       cy_i,
  input  logic       ac_i,
  output logic [7:0] acc_o,
  output logic       cy_o
);
  digit_t lo_adj, hi_adj;
  logic   lo_carry, cy_adj;
  byte_t  adj_byte;

  bcd_lo_fix u_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nib_i   (acc_i[DIG_W-1:0]),
    .ac_i    (ac_i),
    .nib_o   (lo_adj),
    .carry_o (lo_carry)
  );

  bcd_hi_fix u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nib_i  (acc_i[BYTE_W-1:DIG_W]),
    .cin_i  (lo_carry),
    .cy_i   (cy_i),
    .nib_o  (hi_adj),
    .cy_o   (cy_adj)
  );

  assign adj_byte = {hi_adj, lo_adj};

  generate
    if (REG_OUT) begin : g_reg
      byte_t acc_q;
      logic  cy_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          acc_q <= '0;
          cy_q  <= 1'b0;
        end else begin
          acc_q <= adj_byte;
          cy_q  <= cy_adj;
        end
      end
      assign acc_o = acc_q;
      assign cy_o  = cy_q;

      AST_REG_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (acc_o == $past(adj_byte) && cy_o == $past(cy_adj))); // R9
      AST_REG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cy_i |=> cy_o); // R7
    end else begin : g_comb
      assign acc_o = adj_byte;
      assign cy_o  = cy_adj;

      AST_COMB_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_o[0] == acc_i[0]); // R10
    end
  endgenerate

  AST_LO_CARRY_INTO_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_carry && !cy_i && acc_i[7:4] < 4'd8) |-> (hi_adj == acc_i[7:4] + 4'd1)); // R4
  AST_HI_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cy_i && acc_i[7:4] >= 4'd10) |-> cy_adj); // R6
endmodule

// File: tb/tb_bcd_adj_unit.sv
module tb_bcd_adj_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc;
  logic       cy, ac;
  logic [7:0] acc_r, acc_c;
  logic       cy_r, cy_c;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_adj_unit #(.REG_OUT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .cy_i(cy), .ac_i(ac),
    .acc_o(acc_r), .cy_o(cy_r));

  bcd_adj_unit #(.REG_OUT(1'b0)) dut_c (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .cy_i(cy), .ac_i(ac),
    .acc_o(acc_c), .cy_o(cy_c));

  function automatic logic [8:0] ref_adj(input logic [7:0] a, input logic c, input logic h);
    int t = a;
    int fc = c;
    if ((a % 16) > 9 || h) begin
      t = t + 6;
      if (t > 255) fc = 1;
      t = t % 256;
    end
    if ((t / 16) > 9 || fc) begin
      t = t + 96;
      if (t > 255) fc = 1;
      t = t % 256;
    end
    return {fc[0], t[7:0]};
  endfunction

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got cy=%0b acc=%02h expected cy=%0b acc=%02h",
               req, got[8], got[7:0], exp[8], exp[7:0]);
    end
  endtask

  // apply at negedge; comb sampled before edge, reg after edge
  task automatic apply(input string req, input logic [7:0] a, input logic c, input logic h);
    logic [8:0] exp;
    @(negedge clk);
    acc = a; cy = c; ac = h;
    exp = ref_adj(a, c, h);
    #1;
    check({req, " comb R10"}, {cy_c, acc_c}, exp);
    @(posedge clk); #1;
    check({req, " reg R9"}, {cy_r, acc_r}, exp);
  endtask

  task automatic t_reset;
    acc = 8'h99; cy = 1'b1; ac = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", {cy_r, acc_r}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_directed;
    apply("R8 valid passthrough", 8'h47, 1'b0, 1'b0);
    apply("R8 zero", 8'h00, 1'b0, 1'b0);
    apply("R3 low 9 kept", 8'h29, 1'b0, 1'b0);
    apply("R2 low over 9", 8'h1C, 1'b0, 1'b0);
    apply("R2 low via ac", 8'h38, 1'b0, 1'b1);
    apply("R1 bit0 odd", 8'h0F, 1'b0, 1'b0);
    apply("R4 low carry into high", 8'h8A, 1'b0, 1'b0);
    apply("R4 carry chain R6", 8'h9A, 1'b0, 1'b0);
    apply("R4 high F overflow R6", 8'hFF, 1'b0, 1'b0);
    apply("R5 high over 9", 8'hB3, 1'b0, 1'b0);
    apply("R5 high via cy R7", 8'h12, 1'b1, 1'b0);
    apply("R7 sticky no fix needed", 8'h99, 1'b1, 1'b1);
  endtask

  task automatic t_sweep;
    for (int f = 0; f < 4; f++) begin
      for (int v = 0; v < 256; v++) begin
        apply("R5 R6 sweep", v[7:0], f[1], f[0]);
      end
    end
  endtask

  task automatic t_bit0;
    for (int v = 0; v < 256; v += 37) begin
      @(negedge clk);
      acc = v[7:0]; cy = 1'b0; ac = 1'b1;
      #1;
      check("R1 bit0", {8'h00, acc_c[0]}, {8'h00, v[0]});
    end
  endtask

  initial begin
    t_reset();
    t_directed();
    t_bit0();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule